// File: doc/BRIEF.md
# SD Host Command-Issue Register Controller

This block holds the command-issue word of an SD host controller and decides, write by write, whether software may launch a command. Software writes the word over a simple register bus. The block checks two status flags from the command and data engines before it accepts the write. If the command engine is busy, every write is refused. If the data lines are busy, a write that asks for a data phase is refused. When a write is accepted, the block emits a one-cycle start strobe that carries the command index, the command class and the data-present flag. When a write is refused, a sticky error flag is set.

The block also decodes the two-bit command class into four kinds: plain, suspend, resume and abort. It drives level controls toward the data path from that class. Read-wait is released and busy checking is switched off by a suspend. Both are restored by a resume. Buffer filling is halted, or the data lines are released, by an abort, and that state holds until software issues a soft reset. A separate control word lets software request a transfer restart, for example after a suspend the card did not accept, and issue that soft reset.

Top module: `sd_cmd_issue_ctrl`

## Requirements
- R1: After reset, the command word (offset 0x0C) and the error word (offset 0x10) read as zero, busy_check_en is 1, and rd_wait_release, int_period, buf_wr_stop, dat_release, cmd_start and restart_req are 0.
- R2: An accepted write stores only the defined fields and masks the other bits to zero on readback. The defined fields are the command index at bits 29:24, the command class at bits 23:22 (00 plain, 01 suspend, 10 resume, 11 abort), the data-present flag at bit 21 and the data-control field at bits 5:0.
- R3: While cmd_inhibit is 1, a write to the command word leaves it unchanged and produces no cmd_start.
- R4: While dat_inhibit is 1, a write with bit 21 set is dropped. A write with bit 21 clear is accepted.
- R5: While xfer_active is 1, an accepted write keeps the previous bits 5:0 and updates all other defined fields.
- R6: An accepted write raises cmd_start for exactly one cycle, in the cycle after the write. cmd_index, cmd_type and cmd_dp then equal the written fields.
- R7: A dropped write sets bit 0 of the error word. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R8: An accepted suspend sets rd_wait_release when xfer_is_write is 0 and clears busy_check_en when xfer_is_write is 1. It also loads int_period with bus_4bit.
- R9: An accepted resume clears rd_wait_release and int_period and sets busy_check_en.
- R10: An accepted abort sets buf_wr_stop when xfer_is_write is 0 and dat_release when xfer_is_write is 1. Both hold through later commands until 1 is written to bit 1 of the control word (offset 0x14), which clears both.
- R11: Writing 1 to bit 0 of the control word raises restart_req for one cycle. It also clears rd_wait_release and int_period and sets busy_check_en.
- R12: An accepted plain command leaves all data-path controls unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cmd_inhibit | input | 1 | Command engine busy |
| dat_inhibit | input | 1 | Data lines busy |
| xfer_active | input | 1 | Data transfer in progress |
| xfer_is_write | input | 1 | Current transfer direction is write |
| bus_4bit | input | 1 | Data bus in 4-bit mode |
| cmd_start | output | 1 | One-cycle command launch strobe |
| cmd_index | output | 6 | Index of launched command |
| cmd_type | output | 2 | Class of launched command |
| cmd_dp | output | 1 | Launched command has a data phase |
| rd_wait_release | output | 1 | Release read-wait on the data lines |
| busy_check_en | output | 1 | Check card busy before writing |
| int_period | output | 1 | Interrupt period open on 4-bit bus |
| buf_wr_stop | output | 1 | Stop filling the data buffer |
| dat_release | output | 1 | Stop driving the data lines |
| restart_req | output | 1 | One-cycle transfer restart request |

## Verification
The embedded assertions check the following on every cycle:
- A write refused for command-busy changes nothing and starts nothing.
- The data-control field is frozen during an active transfer.
- A refused write always leaves the error flag set.
- Every start strobe traces back to an accepted write.
- The abort controls cannot drop without a soft reset.
- Suspend, resume, restart and plain commands move the controls as required.

Only the bench's sweep shows the rest. It covers every index, class, data-present and inhibit combination, with masked readback of the stored word and the exact fields on the strobe. It also covers how suspend, resume, abort and soft reset combine over long command sequences.

// File: rtl/sd_cmd_pkg.sv
// Package: field positions, masks and types shared by the command-issue
// controller. Bit positions follow the stored command word (LSB = bit 0).
package sd_cmd_pkg;
    localparam int REG_W    = 32;
    localparam int IDX_W    = 6;
    localparam int IDX_LSB  = 24;
    localparam int TYPE_W   = 2;
    localparam int TYPE_LSB = 22;
    localparam int DP_BIT   = 21;
    localparam int DCTL_W   = 6;
    localparam logic [REG_W-1:0] WORD_MASK =
        (((REG_W'(1) << IDX_W) - 1) << IDX_LSB) |
        (((REG_W'(1) << TYPE_W) - 1) << TYPE_LSB) |
        (REG_W'(1) << DP_BIT) |
        ((REG_W'(1) << DCTL_W) - 1);

    typedef enum logic [TYPE_W-1:0] {
        CT_PLAIN   = 2'b00,
        CT_SUSPEND = 2'b01,
        CT_RESUME  = 2'b10,
        CT_ABORT   = 2'b11
    } cmd_class_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        cmd_class_e       ctype;
        logic             dp;
    } cmd_desc_t;
endpackage

// File: rtl/sd_xfer_word.sv
// Module: command-word store with write gating.
// Decides per write whether the command is accepted, keeps the masked word,
// freezes the data-control field during an active transfer, launches a
// one-cycle start strobe and keeps the sticky drop flag.
// Assumes at most one bus write per cycle.
module sd_xfer_word
    import sd_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wdata,
    input  logic             cmd_inhibit,
    input  logic             dat_inhibit,
    input  logic             xfer_active,
    input  logic             err_clr,
    output logic [REG_W-1:0] word_q,
    output logic             err_q,
    output logic             go,
    output cmd_class_e       go_class,
    output logic             start_q,
    output cmd_desc_t        desc_q
);
    logic             drop;
    logic [REG_W-1:0] word_d;

    // Gate the write against the two busy flags.
    always_comb begin
        drop     = wr_hit && (cmd_inhibit || (dat_inhibit && wdata[DP_BIT]));
        go       = wr_hit && !drop;
        go_class = cmd_class_e'(wdata[TYPE_LSB +: TYPE_W]);
    end

    // Build the next stored word, holding the data-control field while busy.
    always_comb begin
        word_d = wdata & WORD_MASK;
        if (xfer_active)
            word_d[DCTL_W-1:0] = word_q[DCTL_W-1:0];
    end

    // Stored command word.
    always_ff @(posedge clk) begin
        if (!rst_n)  word_q <= '0;
        else if (go) word_q <= word_d;
    end

    // Sticky drop flag, set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (drop)    err_q <= 1'b1;
        else if (err_clr) err_q <= 1'b0;
    end

    // Launch strobe with the fields of the accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            desc_q  <= '0;
        end else begin
            start_q <= go;
            if (go) begin
                desc_q.idx   <= wdata[IDX_LSB +: IDX_W];
                desc_q.ctype <= go_class;
                desc_q.dp    <= wdata[DP_BIT];
            end
        end
    end

    a_r3_inhibit_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && cmd_inhibit) |=> $stable(word_q));
    a_r3_inhibit_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && cmd_inhibit) |=> !start_q);
    a_r5_dctl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && xfer_active) |=> $stable(word_q[DCTL_W-1:0]));
    a_r7_drop_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && cmd_inhibit) |=> err_q);
    a_r6_start_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> $past(wr_hit && !cmd_inhibit));
endmodule

// File: rtl/sd_dpath_ctl.sv
// Module: data-path control from the command class.
// Suspend and resume toggle read-wait release, busy checking and the
// interrupt period. Abort latches buffer-stop or data-line release until a
// soft reset. A restart request undoes the suspend effects.
// Assumes go, restart and sreset are never active in the same cycle.
module sd_dpath_ctl
    import sd_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  cmd_class_e go_class,
    input  logic       xfer_is_write,
    input  logic       bus_4bit,
    input  logic       restart,
    input  logic       sreset,
    output logic       rd_wait_release,
    output logic       busy_check_en,
    output logic       int_period,
    output logic       buf_wr_stop,
    output logic       dat_release,
    output logic       restart_req
);
    // Suspend/resume/restart controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_wait_release <= 1'b0;
            busy_check_en   <= 1'b1;
            int_period      <= 1'b0;
        end else if (restart || (go && go_class == CT_RESUME)) begin
            rd_wait_release <= 1'b0;
            busy_check_en   <= 1'b1;
            int_period      <= 1'b0;
        end else if (go && go_class == CT_SUSPEND) begin
            if (xfer_is_write) busy_check_en <= 1'b0;
            else               rd_wait_release <= 1'b1;
            int_period <= bus_4bit;
        end
    end

    // Abort controls, held until soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || sreset) begin
            buf_wr_stop <= 1'b0;
            dat_release <= 1'b0;
        end else if (go && go_class == CT_ABORT) begin
            if (xfer_is_write) dat_release <= 1'b1;
            else               buf_wr_stop <= 1'b1;
        end
    end

    // One-cycle restart request.
    always_ff @(posedge clk) begin
        if (!rst_n) restart_req <= 1'b0;
        else        restart_req <= restart;
    end

    a_r8_suspend_read: assert property (@(posedge clk) disable iff (!rst_n)
        (go && go_class == CT_SUSPEND && !xfer_is_write) |=> rd_wait_release);
    a_r9_resume_busy_on: assert property (@(posedge clk) disable iff (!rst_n)
        (go && go_class == CT_RESUME) |=> (busy_check_en && !rd_wait_release));
    a_r10_abort_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((buf_wr_stop || dat_release) && !sreset) |=>
        ($stable(buf_wr_stop) || buf_wr_stop) && ($stable(dat_release) || dat_release));
    a_r11_restart_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (restart_req && !rd_wait_release && !int_period));
    a_r12_plain_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (go && go_class == CT_PLAIN) |=>
        $stable({rd_wait_release, busy_check_en, int_period, buf_wr_stop, dat_release}));
endmodule

// File: rtl/sd_cmd_issue_ctrl.sv
// Module: top of the SD host command-issue controller.
// Decodes the register bus into the command word, the error word and the
// control word, and wires the write gate to the data-path control.
// Assumes a single-cycle write strobe and combinational reads.
module sd_cmd_issue_ctrl
    import sd_cmd_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] XFER_OFS = 'h0C,
    parameter logic [ADDR_W-1:0] ERR_OFS  = 'h10,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              cmd_inhibit,
    input  logic              dat_inhibit,
    input  logic              xfer_active,
    input  logic              xfer_is_write,
    input  logic              bus_4bit,
    output logic              cmd_start,
    output logic [IDX_W-1:0]  cmd_index,
    output logic [TYPE_W-1:0] cmd_type,
    output logic              cmd_dp,
    output logic              rd_wait_release,
    output logic              busy_check_en,
    output logic              int_period,
    output logic              buf_wr_stop,
    output logic              dat_release,
    output logic              restart_req
);
    logic             xfer_hit, err_clr, restart, sreset;
    logic             go, err_q;
    cmd_class_e       go_class;
    logic [REG_W-1:0] word_q;
    cmd_desc_t        desc_q;

    // Address decode of the three words.
    always_comb begin
        xfer_hit = bus_wr && (bus_addr == XFER_OFS);
        err_clr  = bus_wr && (bus_addr == ERR_OFS) && bus_wdata[0];
        restart  = bus_wr && (bus_addr == CTRL_OFS) && bus_wdata[0];
        sreset   = bus_wr && (bus_addr == CTRL_OFS) && bus_wdata[1];
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == XFER_OFS)     bus_rdata = word_q;
        else if (bus_addr == ERR_OFS) bus_rdata[0] = err_q;
    end

    sd_xfer_word u_word (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hit      (xfer_hit),
        .wdata       (bus_wdata),
        .cmd_inhibit (cmd_inhibit),
        .dat_inhibit (dat_inhibit),
        .xfer_active (xfer_active),
        .err_clr     (err_clr),
        .word_q      (word_q),
        .err_q       (err_q),
        .go          (go),
        .go_class    (go_class),
        .start_q     (cmd_start),
        .desc_q      (desc_q)
    );

    sd_dpath_ctl u_ctl (
        .clk             (clk),
        .rst_n           (rst_n),
        .go              (go),
        .go_class        (go_class),
        .xfer_is_write   (xfer_is_write),
        .bus_4bit        (bus_4bit),
        .restart         (restart),
        .sreset          (sreset),
        .rd_wait_release (rd_wait_release),
        .busy_check_en   (busy_check_en),
        .int_period      (int_period),
        .buf_wr_stop     (buf_wr_stop),
        .dat_release     (dat_release),
        .restart_req     (restart_req)
    );

    // Launch fields toward the command engine.
    always_comb begin
        cmd_index = desc_q.idx;
        cmd_type  = desc_q.ctype;
        cmd_dp    = desc_q.dp;
    end

    a_r4_dat_inhibit_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_hit && dat_inhibit && bus_wdata[DP_BIT]) |=> (!cmd_start && err_q));
endmodule

// File: tb/sim_sd_cmd_issue_ctrl.sv
`timescale 1ns/1ps
module sim_sd_cmd_issue_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cmd_inhibit = 1'b0, dat_inhibit = 1'b0, xfer_active = 1'b0;
    logic        xfer_is_write = 1'b0, bus_4bit = 1'b0;
    logic        cmd_start, cmd_dp;
    logic [5:0]  cmd_index;
    logic [1:0]  cmd_type;
    logic        rd_wait_release, busy_check_en, int_period;
    logic        buf_wr_stop, dat_release, restart_req;

    int checks = 0, errors = 0;
    bit done = 0;

    // model state
    logic [31:0] e_word = '0;
    logic e_err = 0, e_rdrel = 0, e_bchk = 1, e_intp = 0, e_bws = 0, e_drel = 0;

    always #2.5 clk = ~clk;

    sd_cmd_issue_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmd_inhibit(cmd_inhibit), .dat_inhibit(dat_inhibit),
        .xfer_active(xfer_active), .xfer_is_write(xfer_is_write), .bus_4bit(bus_4bit),
        .cmd_start(cmd_start), .cmd_index(cmd_index), .cmd_type(cmd_type), .cmd_dp(cmd_dp),
        .rd_wait_release(rd_wait_release), .busy_check_en(busy_check_en),
        .int_period(int_period), .buf_wr_stop(buf_wr_stop), .dat_release(dat_release),
        .restart_req(restart_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one write cycle; returns right after the next falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_ctl(input string req);
        chk(req, {27'd0, rd_wait_release, busy_check_en, int_period, buf_wr_stop, dat_release},
            {27'd0, e_rdrel, e_bchk, e_intp, e_bws, e_drel});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(8'h0C, r); chk("R1 word", r, 0);
        rd(8'h10, r); chk("R1 err", r, 0);
        chk_ctl("R1 ctl");
        chk("R1 start/restart", {cmd_start, restart_req}, 0);

        // R11: suspend on 4-bit read, then restart request
        bus_4bit = 1; xfer_is_write = 0;
        wr(8'h0C, 32'h0500_0000 | (32'h1 << 22));
        e_rdrel = 1; e_intp = 1; e_word = 32'h0540_0000;
        chk_ctl("R8 suspend 4-bit read");
        wr(8'h14, 32'h1);
        e_rdrel = 0; e_intp = 0; e_bchk = 1;
        chk("R11 restart pulse", restart_req, 1);
        chk_ctl("R11 restart clears");
        @(negedge clk);
        chk("R11 restart one cycle", restart_req, 0);

        // R7: write 0 does not clear, write 1 clears
        cmd_inhibit = 1;
        wr(8'h0C, 32'h0100_0000);
        cmd_inhibit = 0; e_err = 1;
        wr(8'h10, 32'h0);
        rd(8'h10, r); chk("R7 write 0 keeps", r, 1);
        wr(8'h10, 32'h1); e_err = 0;
        rd(8'h10, r); chk("R7 write 1 clears", r, 0);
        @(negedge clk);
        chk("R6 single pulse", cmd_start, 0);

        // near-exhaustive sweep
        for (int i = 0; i < 2048; i++) begin
            logic [10:0] b;
            logic [5:0]  idx;
            logic [1:0]  typ;
            logic        dp, ci, di, acc;
            logic [31:0] wd;
            string       tg;
            b = 11'(i);
            idx = b[5:0]; typ = b[7:6]; dp = b[8]; ci = b[9]; di = b[10];
            cmd_inhibit = ci; dat_inhibit = di;
            xfer_active = b[1] ^ b[3]; xfer_is_write = b[2]; bus_4bit = b[4];
            wd = (32'(idx) << 24) | (32'(typ) << 22) | (32'(dp) << 21) | (32'(i * 7) & 32'h3F);
            if (b[3]) wd = wd | 32'h8000_0400;
            acc = !ci && !(di && dp);
            wr(8'h0C, wd);
            if (acc) begin
                logic [31:0] nw;
                nw = wd & 32'h3FE0_003F;
                if (xfer_active) nw[5:0] = e_word[5:0];
                e_word = nw;
                case (typ)
                    2'd1: begin
                        if (xfer_is_write) e_bchk = 0; else e_rdrel = 1;
                        e_intp = bus_4bit;
                    end
                    2'd2: begin e_rdrel = 0; e_intp = 0; e_bchk = 1; end
                    2'd3: begin
                        if (xfer_is_write) e_drel = 1; else e_bws = 1;
                    end
                    default: ;
                endcase
            end else e_err = 1;
            tg = ci ? "R3" : (di && dp) ? "R4" : "R6";
            chk(tg, cmd_start, acc);
            if (acc) chk("R6 fields", {23'd0, cmd_index, cmd_type, cmd_dp}, {23'd0, idx, typ, dp});
            rd(8'h0C, r);
            chk(xfer_active ? "R5" : "R2", r, e_word);
            rd(8'h10, r); chk("R7 err", r, 32'(e_err));
            case (typ)
                2'd0: chk_ctl("R12 plain");
                2'd1: chk_ctl("R8 suspend");
                2'd2: chk_ctl("R9 resume");
                default: chk_ctl("R10 abort");
            endcase
            cmd_inhibit = 0; dat_inhibit = 0;
            wr(8'h10, 32'h1); e_err = 0;
            if (typ == 2'd3 && b[5]) begin
                wr(8'h14, 32'h2); e_bws = 0; e_drel = 0;
                chk_ctl("R10 soft reset");
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule